// File: doc/BRIEF.md
# DAC Update-Rate Timer with Staged Sample Buffer

This block paces the sample stream of a digital-to-analog converter. Software or a DMA engine writes samples and settings over a small 32-bit register bus. A hidden down-counter, advanced by a rate tick, marks each update period. Every time the counter expires it reloads, raises a request flag that can be forwarded to a DMA controller, and, when staging is active, moves the staged sample into the converter output register.

When staging is off, a sample write goes straight to the output on the next clock. When both the counter and staging are enabled, writes to the sample address land in a hidden stage register instead. The output then changes only on the counter's expiry, so update timing no longer depends on bus latency. Reading the sample address always returns the value currently driven to the converter.

Top module: `dac_rate_timer`

## Requirements
- R1: After synchronous reset, `dac_data` is 0, `dma_req` is 0, and every register reads back as 0.
- R2: Word address 1 is control: bit 0 reads the request flag, bit 1 enables staging, bit 2 enables the counter, bit 3 gates the request output, and all other bits read 0. Address 2 holds the reload value in bits 15:0, and its upper bits read 0. Address 3 reads 0 and ignores writes. Read data appears on `bus_rdata` one clock after `bus_rd`.
- R3: While the counter is disabled it follows the reload value. While it is enabled, each clock with `tick` high decrements it. With reload value N, the expiry happens on tick number N+1 after enabling, and the counter then restarts from N. Without a tick the counter does not move.
- R4: Each expiry sets the request flag, which stays set until it is cleared and is visible in control bit 0.
- R5: `dma_req` is high only while the request flag is set and control bit 3 is 1. With bit 3 at 0 the flag still sets but `dma_req` stays low.
- R6: The flag clears on a `dma_ack` pulse or on a control write with bit 0 at 1. When an expiry and a clear happen in the same clock, the flag stays set.
- R7: With staging inactive, a write to address 0 drives `bus_wdata[DATA_W-1:0]` onto `dac_data` at the next clock edge.
- R8: Staging is active only when both control bits 1 and 2 are set. A write to address 0 then loads only the stage register and leaves `dac_data` unchanged. With bit 1 set and bit 2 clear, writes behave as in R7.
- R9: With staging active, an expiry copies the stage register to `dac_data` on the same clock edge that reloads the counter and sets the flag, and not earlier.
- R10: Reading address 0 returns the current `dac_data` zero-extended, never the staged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rd | input | 1 | Register read strobe |
| bus_rdata | output | 32 | Registered read data |
| tick | input | 1 | Update-rate enable, one clock wide per count step |
| dma_req | output | 1 | Gated transfer request |
| dma_ack | input | 1 | Request acknowledge, clears the flag |
| dac_data | output | DATA_W | Sample driven to the converter |

## Verification
Register writes, direct sample updates, flag changes and staged commits all appear one clock after the edge that samples the stimulus. Read data appears one clock after the read strobe. The expiry lands on the edge that consumes tick N+1. The bench drives every input on the falling edge and samples on the next falling edge, so each result is read exactly one edge after its cause. The timing sweep counts the ticks delivered until `dma_req` first rises and compares that count with N+1, for reload values 0 to 6 and tick spacings of 1, 2 and 3 clocks.

// File: rtl/dac_tmr_pkg.sv
package dac_tmr_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_SAMPLE = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_RELOAD = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  // control bit positions
  localparam int CB_FLAG = 0;
  localparam int CB_STG  = 1;
  localparam int CB_RUN  = 2;
  localparam int CB_REQ  = 3;

  typedef struct packed {
    logic req_en;
    logic run_en;
    logic stg_en;
  } ctrl_t;
endpackage

// File: rtl/dac_tmr_counter.sv
module dac_tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic             expire,
  output logic [CNT_W-1:0] cnt_q
);
  assign expire = run & tick & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= reload;
    end else if (tick) begin
      cnt_q <= expire ? reload : cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dac_tmr_flag.sv
module dac_tmr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic gate,
  output logic flag_q,
  output logic req
);
  // a new expiry outranks a clear in the same clock
  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign req = flag_q & gate;
endmodule

// File: rtl/dac_tmr_sample.sv
module dac_tmr_sample #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              staged,
  input  logic              commit,
  output logic [DATA_W-1:0] out_q,
  output logic [DATA_W-1:0] stage_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      stage_q <= '0;
    end else if (wr && !staged) begin
      out_q   <= wdata;
      stage_q <= wdata;
    end else begin
      if (wr)               stage_q <= wdata;
      if (commit && staged) out_q   <= stage_q;
    end
  end
endmodule

// File: rtl/dac_rate_timer.sv
module dac_rate_timer
  import dac_tmr_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              tick,
  output logic              dma_req,
  input  logic              dma_ack,
  output logic [DATA_W-1:0] dac_data
);
  reg_sel_e         sel;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DATA_W-1:0] stage_q;
  logic             wr_sample, wr_ctrl, wr_reload;
  logic             staged, expire, req_flag, flag_clr;
  logic [BUS_W-1:0] rd_mux;
  logic             wdata_unused;

  assign sel          = reg_sel_e'(bus_addr);
  assign wr_sample    = bus_wr && (sel == SEL_SAMPLE);
  assign wr_ctrl      = bus_wr && (sel == SEL_CTRL);
  assign wr_reload    = bus_wr && (sel == SEL_RELOAD);
  assign staged       = ctrl_q.run_en & ctrl_q.stg_en;
  assign flag_clr     = dma_ack | (wr_ctrl & bus_wdata[CB_FLAG]);
  assign wdata_unused = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.stg_en <= bus_wdata[CB_STG];
        ctrl_q.run_en <= bus_wdata[CB_RUN];
        ctrl_q.req_en <= bus_wdata[CB_REQ];
      end
      if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  dac_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .run    (ctrl_q.run_en),
    .tick   (tick),
    .reload (reload_q),
    .expire (expire),
    .cnt_q  (cnt_q)
  );

  dac_tmr_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set    (expire),
    .clr    (flag_clr),
    .gate   (ctrl_q.req_en),
    .flag_q (req_flag),
    .req    (dma_req)
  );

  dac_tmr_sample #(.DATA_W(DATA_W)) u_smp (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr_sample),
    .wdata   (bus_wdata[DATA_W-1:0]),
    .staged  (staged),
    .commit  (expire),
    .out_q   (dac_data),
    .stage_q (stage_q)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_SAMPLE: rd_mux = BUS_W'(dac_data);
      SEL_CTRL: begin
        rd_mux[CB_FLAG] = req_flag;
        rd_mux[CB_STG]  = ctrl_q.stg_en;
        rd_mux[CB_RUN]  = ctrl_q.run_en;
        rd_mux[CB_REQ]  = ctrl_q.req_en;
      end
      SEL_RELOAD: rd_mux = BUS_W'(reload_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/dac_tmr_chk.sv
module dac_tmr_chk
  import dac_tmr_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              tick,
  input logic              dma_ack,
  input logic              dma_req,
  input logic [DATA_W-1:0] dac_data,
  input logic              run_en,
  input logic              staged,
  input logic              expire,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              req_flag,
  input logic [DATA_W-1:0] stage_q
);
  logic ctrl_wr, smp_wr;
  assign ctrl_wr = bus_wr && (bus_addr == 2'd1);
  assign smp_wr  = bus_wr && (bus_addr == 2'd0);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!dma_req && dac_data == '0));

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (run_en && !tick && !ctrl_wr) |=> $stable(cnt_q));

  assert_expire_sets_R6: assert property (@(posedge clk) disable iff (rst)
    expire |=> req_flag);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (dma_ack && !expire) |=> !dma_req);

  assert_direct_write_R7: assert property (@(posedge clk) disable iff (rst)
    (smp_wr && !staged) |=> (dac_data == $past(bus_wdata[DATA_W-1:0])));

  assert_staged_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (smp_wr && staged && !expire) |=> $stable(dac_data));

  assert_commit_R9: assert property (@(posedge clk) disable iff (rst)
    (expire && staged && !smp_wr) |=> (dac_data == $past(stage_q)));
endmodule

bind dac_rate_timer dac_tmr_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .tick      (tick),
  .dma_ack   (dma_ack),
  .dma_req   (dma_req),
  .dac_data  (dac_data),
  .run_en    (ctrl_q.run_en),
  .staged    (staged),
  .expire    (expire),
  .cnt_q     (cnt_q),
  .req_flag  (req_flag),
  .stage_q   (stage_q)
);

// File: tb/tb_dac_rate_timer.sv
module tb_dac_rate_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    bus_addr;
  logic          bus_wr, bus_rd, tick, dma_ack;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          dma_req;
  logic [DW-1:0] dac_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_rate_timer #(.DATA_W(DW), .CNT_W(16)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tick(tick), .dma_req(dma_req), .dma_ack(dma_ack), .dac_data(dac_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cnt;
    int cyc;
    rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    tick = 0; dma_ack = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(dac_data == 0, "R1 dac_data", 32'(dac_data), 0);
    chk(dma_req == 0, "R1 dma_req", 32'(dma_req), 0);
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), v);
      chk(v == 0, "R1 register readback", v, 0);
    end

    // R2 register map
    wr(2'd2, 32'hABCD_1234);
    rd(2'd2, v); chk(v == 32'h1234, "R2 reload", v, 32'h1234);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk(v == 32'hE, "R2 control", v, 32'hE);
    wr(2'd1, 32'h1);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk(v == 0, "R2 spare", v, 0);

    // R7 direct write, R8 staging needs both enables
    wr(2'd0, 32'hFFFF_FABC);
    chk(dac_data == 12'hABC, "R7 direct write", 32'(dac_data), 32'hABC);
    rd(2'd0, v); chk(v == 32'hABC, "R10 readback", v, 32'hABC);
    wr(2'd1, 32'h2);
    wr(2'd0, 32'h123);
    chk(dac_data == 12'h123, "R8 stage without counter", 32'(dac_data), 32'h123);

    // R3 R4 R5 period sweep
    for (int gap = 1; gap <= 3; gap++) begin
      for (int r = 0; r <= 6; r++) begin
        wr(2'd1, 32'h1);
        wr(2'd2, 32'(r));
        wr(2'd1, 32'hC);
        cnt = 0; cyc = 0;
        while (!dma_req && cyc < 200) begin
          tick = ((cyc % gap) == 0);
          @(negedge clk);
          if (tick) cnt++;
          cyc++;
        end
        tick = 1'b0;
        chk(cnt == r + 1, "R3 expiry tick count", 32'(cnt), 32'(r + 1));
      end
    end

    // R6 acknowledge
    dma_ack = 1'b1; @(negedge clk); dma_ack = 1'b0;
    chk(dma_req == 0, "R6 ack clears", 32'(dma_req), 0);

    // R5 gating
    wr(2'd1, 32'h1);
    wr(2'd2, 32'd2);
    wr(2'd1, 32'h4);
    ticks(3);
    chk(dma_req == 0, "R5 gated off", 32'(dma_req), 0);
    rd(2'd1, v); chk(v == 32'h5, "R4 flag visible", v, 32'h5);
    wr(2'd1, 32'hC);
    chk(dma_req == 1, "R5 gate opened", 32'(dma_req), 1);

    // R6 set beats clear, software clear
    wr(2'd1, 32'h1);
    wr(2'd2, 32'd0);
    wr(2'd1, 32'hC);
    ticks(1);
    dma_ack = 1'b1; tick = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0; tick = 1'b0;
    chk(dma_req == 1, "R6 expiry wins over ack", 32'(dma_req), 1);
    wr(2'd1, 32'hD);
    chk(dma_req == 0, "R6 software clear", 32'(dma_req), 0);

    // R8 R9 R10 staged mode
    wr(2'd1, 32'h1);
    wr(2'd0, 32'h111);
    wr(2'd2, 32'd3);
    wr(2'd1, 32'hE);
    wr(2'd0, 32'h5A5);
    chk(dac_data == 12'h111, "R8 staged write holds output", 32'(dac_data), 32'h111);
    rd(2'd0, v); chk(v == 32'h111, "R10 read returns output", v, 32'h111);
    ticks(3);
    chk(dac_data == 12'h111, "R9 no early commit", 32'(dac_data), 32'h111);
    ticks(1);
    chk(dac_data == 12'h5A5, "R9 commit on expiry", 32'(dac_data), 32'h5A5);
    chk(dma_req == 1, "R9 flag with commit", 32'(dma_req), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule